// File: doc/BRIEF.md
# Receive Destination Address Filter

This block watches the receive byte stream of a network interface and decides, for each frame, whether the frame should travel on toward the host or be thrown away at the interface. The decision rests on the 48-bit destination address carried in the first six bytes of the frame. A frame passes when its address equals the station's own address, when it is the all-ones broadcast address, or when it is a group (multicast) address whose hash selects a set bit in a 64-bit map that software loads. A promiscuous control input passes every frame. The hash screen is not exact, so some group addresses that software never asked for may get through.

The stream arrives one byte per clock cycle while `rx_valid` is high, with `rx_sof` marking the first byte and `rx_eof` the last. Once the sixth byte has been taken, the block raises `verdict_valid` with the pass/drop result on `verdict_accept`. For passed frames it also raises a one-cycle interrupt request. Dropped frames produce no interrupt, and a downstream stage can use the verdict to keep them off the host bus. Payload storage and frame check sequence validation belong to other blocks.

Top module: `rx_addr_filter`

## Requirements
- R1: While reset is held and in the first cycle after it, `verdict_valid`, `verdict_accept` and `irq_pulse` are all 0.
- R2: The first destination byte received forms address bits 47:40 and the sixth forms bits 7:0. A frame whose address equals `own_mac` is accepted.
- R3: A frame whose 48 destination bits are all 1 is accepted, whatever the hash map holds.
- R4: A frame is a group frame when bit 0 of its first byte (address bit 40) is 1. A group frame that is not broadcast and does not equal `own_mac` is accepted exactly when `hash_map[idx]` is 1. The value `idx` is bits 31:26 of a CRC-32 register that starts at all ones and is updated over the six address bytes in arrival order, each byte least significant bit first, with the reflected polynomial 0xEDB88320 and no final complement. Unregistered groups that share an index are therefore accepted.
- R5: A frame whose address has bit 40 clear and does not equal `own_mac` is dropped when `promisc` is 0, and it raises no interrupt.
- R6: With `promisc` at 1 when the sixth byte is taken, every frame of at least six bytes is accepted.
- R7: `verdict_valid` rises in the cycle after the clock edge that takes the sixth byte. From then on it and `verdict_accept` hold their values, even if `own_mac`, `hash_map` or `promisc` change, until the edge that takes the next start-of-frame byte.
- R8: `irq_pulse` is high for exactly one cycle per accepted frame, in the first cycle of `verdict_valid`. It stays low for dropped frames.
- R9: A frame whose end marker arrives within its first five bytes gets no verdict: `verdict_valid` stays 0 and no interrupt is raised. Taking a start-of-frame byte clears any earlier verdict.
- R10: Cycles with `rx_valid` at 0 are ignored, and so are bytes that arrive after an end marker without a start marker. A start marker in the middle of a frame restarts address collection from that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_valid | input | 1 | A stream byte is present this cycle |
| rx_data | input | 8 | Stream byte |
| rx_sof | input | 1 | This byte is the first of a frame |
| rx_eof | input | 1 | This byte is the last of a frame |
| own_mac | input | 48 | Station unicast address, bit 47 in the first byte |
| hash_map | input | 64 | Group hash bitmap loaded by software |
| promisc | input | 1 | Accept every frame of at least six bytes |
| verdict_valid | output | 1 | A verdict is held for the current frame |
| verdict_accept | output | 1 | 1 = pass to host, 0 = drop |
| irq_pulse | output | 1 | One-cycle interrupt request for a passed frame |

## Verification
The hardest case to reach from the ports is a false positive: a group address that software never loaded, but whose CRC index lands on a bit that another group set. Random addresses against a random map reach it only by chance. The bench therefore computes the hash itself, sets the single bit for one chosen group, and then searches random group addresses until it finds a different one with the same index. It sends both addresses, and a third with a different index that must be dropped. Random stimulus also adds idle gaps inside the address, stray bytes after an end marker, frames cut short and restarted, and changes to the filter settings after the verdict is formed, so that the hold behaviour is exercised.

// File: rtl/addr_filter_pkg.sv
// Package: shared constants and the CRC-32 byte step for the address filter.
// Assumes bytes enter the CRC least significant bit first (reflected form).
package addr_filter_pkg;

    localparam int          BYTE_W     = 8;
    localparam int          ADDR_BYTES = 6;
    localparam int          ADDR_W     = ADDR_BYTES * BYTE_W;
    localparam int          CRC_W      = 32;
    localparam logic [31:0] CRC_POLY_R = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED   = 32'hFFFF_FFFF;

    // Advance the reflected CRC register by one byte, least significant bit first.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic [BYTE_W-1:0] d);
        logic [CRC_W-1:0] r;
        r = c;
        for (int b = 0; b < BYTE_W; b++) begin
            r = (r >> 1) ^ (CRC_POLY_R & {CRC_W{r[0] ^ d[b]}});
        end
        return r;
    endfunction

endpackage

// File: rtl/frame_tracker.sv
// Module: frame_tracker
// Follows frame boundaries in the receive stream. It counts the address bytes,
// shifts them into an address register and runs the CRC over them. It flags
// the cycle in which the last address byte is taken, and it offers the
// complete address and CRC as next-state values in that same cycle.
// Assumes one byte per valid cycle. Bytes after an end marker are ignored
// until the next start marker.
module frame_tracker
    import addr_filter_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_sof,
    input  logic              rx_eof,
    output logic [ADDR_W-1:0] addr_cur,
    output logic [CRC_W-1:0]  crc_cur,
    output logic              last_addr_byte,
    output logic              frame_start
);

    localparam int CNT_W = $clog2(ADDR_BYTES + 1);

    logic [CNT_W-1:0]  cnt_q;
    logic              live_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CRC_W-1:0]  crc_q;
    logic              take;

    // Decide whether this byte belongs to the address, and form the next address and CRC.
    always_comb begin
        take           = rx_valid && (rx_sof || (live_q && (cnt_q < CNT_W'(ADDR_BYTES))));
        addr_cur       = {addr_q[ADDR_W-BYTE_W-1:0], rx_data};
        crc_cur        = crc_step(rx_sof ? CRC_SEED : crc_q, rx_data);
        frame_start    = rx_valid && rx_sof;
        last_addr_byte = take && (rx_sof ? (ADDR_BYTES == 1)
                                         : (cnt_q == CNT_W'(ADDR_BYTES - 1)));
    end

    // Hold the byte count, the open-frame flag and the partial address and CRC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            live_q <= 1'b0;
            addr_q <= '0;
            crc_q  <= CRC_SEED;
        end else begin
            if (take) begin
                addr_q <= addr_cur;
                crc_q  <= crc_cur;
                cnt_q  <= rx_sof ? CNT_W'(1) : cnt_q + CNT_W'(1);
            end
            if (rx_valid) begin
                if (rx_eof)      live_q <= 1'b0;
                else if (rx_sof) live_q <= 1'b1;
            end
        end
    end

    // The address count never runs past the address length.
    assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(ADDR_BYTES));

endmodule

// File: rtl/addr_classify.sv
// Module: addr_classify
// Combinational pass/drop decision for a complete destination address:
// own-address match, broadcast, group hash lookup or promiscuous mode.
// Assumes crc_in is the reflected CRC register after all address bytes.
module addr_classify
    import addr_filter_pkg::*;
#(
    parameter int HASH_BITS = 6,
    localparam int MAP_W    = 1 << HASH_BITS
) (
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [ADDR_W-1:0] own_mac,
    input  logic [MAP_W-1:0]  hash_map,
    input  logic              promisc,
    output logic              accept
);

    logic [HASH_BITS-1:0] idx;
    logic                 is_bcast;
    logic                 is_group;
    logic                 own_hit;
    logic                 hash_hit;

    // Classify the address and combine the ways it can pass.
    always_comb begin
        idx      = crc_in[CRC_W-1 -: HASH_BITS];
        is_bcast = &addr_in;
        is_group = addr_in[ADDR_W-BYTE_W];
        own_hit  = (addr_in == own_mac);
        hash_hit = is_group && hash_map[idx];
        accept   = promisc || is_bcast || own_hit || hash_hit;
    end

endmodule

// File: rtl/verdict_reg.sv
// Module: verdict_reg
// Captures the decision when the last address byte is taken, holds it until
// the next start of frame and issues a one-cycle interrupt request for
// accepted frames.
// Assumes a frame start and a last address byte never coincide with the
// default six-byte address.
module verdict_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic last_addr_byte,
    input  logic accept_in,
    input  logic promisc,
    output logic verdict_valid,
    output logic verdict_accept,
    output logic irq_pulse
);

    // Capture, hold or clear the verdict and produce the interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            verdict_valid  <= 1'b0;
            verdict_accept <= 1'b0;
            irq_pulse      <= 1'b0;
        end else begin
            irq_pulse <= 1'b0;
            if (last_addr_byte) begin
                verdict_valid  <= 1'b1;
                verdict_accept <= accept_in;
                irq_pulse      <= accept_in;
            end else if (frame_start) begin
                verdict_valid  <= 1'b0;
                verdict_accept <= 1'b0;
            end
        end
    end

    assert_irq_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    assert_irq_needs_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> (verdict_valid && verdict_accept));

    assert_verdict_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_valid && !frame_start && !last_addr_byte)
        |=> (verdict_valid && $stable(verdict_accept)));

    assert_promisc_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (last_addr_byte && promisc) |=> verdict_accept);

    assert_sof_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !last_addr_byte) |=> !verdict_valid);

endmodule

// File: rtl/rx_addr_filter.sv
// Module: rx_addr_filter (top)
// Receive-path destination address filter: accepts own unicast, broadcast,
// hashed multicast or any frame in promiscuous mode, with a held verdict and
// a one-cycle interrupt request for accepted frames.
// Assumes the first stream byte of the address carries address bits 47:40.
module rx_addr_filter
    import addr_filter_pkg::*;
#(
    parameter int HASH_BITS = 6,
    localparam int MAP_W    = 1 << HASH_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic [ADDR_W-1:0] own_mac,
    input  logic [MAP_W-1:0]  hash_map,
    input  logic              promisc,
    output logic              verdict_valid,
    output logic              verdict_accept,
    output logic              irq_pulse
);

    logic [ADDR_W-1:0] addr_cur;
    logic [CRC_W-1:0]  crc_cur;
    logic              last_addr_byte;
    logic              frame_start;
    logic              accept;

    frame_tracker u_track (
        .clk            (clk),
        .rst_n          (rst_n),
        .rx_valid       (rx_valid),
        .rx_data        (rx_data),
        .rx_sof         (rx_sof),
        .rx_eof         (rx_eof),
        .addr_cur       (addr_cur),
        .crc_cur        (crc_cur),
        .last_addr_byte (last_addr_byte),
        .frame_start    (frame_start)
    );

    addr_classify #(.HASH_BITS(HASH_BITS)) u_class (
        .addr_in  (addr_cur),
        .crc_in   (crc_cur),
        .own_mac  (own_mac),
        .hash_map (hash_map),
        .promisc  (promisc),
        .accept   (accept)
    );

    verdict_reg u_verdict (
        .clk            (clk),
        .rst_n          (rst_n),
        .frame_start    (frame_start),
        .last_addr_byte (last_addr_byte),
        .accept_in      (accept),
        .promisc        (promisc),
        .verdict_valid  (verdict_valid),
        .verdict_accept (verdict_accept),
        .irq_pulse      (irq_pulse)
    );

    // A broadcast address taken as the last address byte always yields a pass.
    assert_bcast_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (last_addr_byte && (&addr_cur)) |=> (verdict_valid && verdict_accept));

endmodule

// File: tb/sim_rx_addr_filter.sv
module sim_rx_addr_filter;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rx_valid;
    logic [7:0]  rx_data;
    logic        rx_sof;
    logic        rx_eof;
    logic [47:0] own_mac;
    logic [63:0] hash_map;
    logic        promisc;
    logic        verdict_valid;
    logic        verdict_accept;
    logic        irq_pulse;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    rx_addr_filter u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_sof(rx_sof), .rx_eof(rx_eof), .own_mac(own_mac), .hash_map(hash_map),
        .promisc(promisc), .verdict_valid(verdict_valid),
        .verdict_accept(verdict_accept), .irq_pulse(irq_pulse)
    );

    // Bit-serial CRC over the 48 address bits, first byte first, LSB first (R4).
    function automatic logic [5:0] bench_hash(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int j = 0; j < 6; j++) begin
            logic [7:0] by = a[47 - 8*j -: 8];
            for (int b = 0; b < 8; b++) begin
                logic fb = c[0] ^ by[b];
                c = c >> 1;
                if (fb) c = c ^ 32'hEDB88320;
            end
        end
        return c[31:26];
    endfunction

    function automatic bit expect_pass(input logic [47:0] a, input int len);
        if (len < 6)       return 1'b0;
        if (promisc)       return 1'b1;
        if (a == own_mac)  return 1'b1;
        if (&a)            return 1'b1;
        if (a[40])         return hash_map[bench_hash(a)];
        return 1'b0;
    endfunction

    function automatic logic [47:0] rand_addr(input bit grp);
        logic [47:0] a = {$urandom, $urandom};
        a[40] = grp;
        if (&a) a[0] = 1'b0;
        return a;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic observe(input int k, input int len, input bit exp_acc,
                           input bit exp_irq, input string tag);
        bit v_exp = (k >= 6) && (len >= 6);
        chk(verdict_valid == v_exp, (len < 6) ? "R9" : "R7", "verdict_valid",
            verdict_valid, v_exp);
        if (v_exp) chk(verdict_accept == exp_acc, tag, "verdict_accept",
                       verdict_accept, exp_acc);
        chk(irq_pulse == exp_irq, "R8", "irq_pulse", irq_pulse, exp_irq);
    endtask

    // Send one frame; inputs change on the falling edge, outputs are read there first.
    task automatic send(input logic [47:0] da, input int len, input bit with_eof,
                        input int gap_pct, input bit poke, input string tag);
        bit          exp  = expect_pass(da, len);
        logic [47:0] om   = own_mac;
        bit          pm   = promisc;
        for (int i = 0; i < len; i++) begin
            if (i > 0) begin
                while ($urandom_range(0, 99) < gap_pct) begin
                    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_data = 8'($urandom);
                    @(negedge clk);
                    observe(i, len, exp, 1'b0, tag);
                end
            end
            rx_valid = 1'b1;
            rx_data  = (i < 6) ? da[47 - 8*i -: 8] : 8'($urandom);
            rx_sof   = (i == 0);
            rx_eof   = with_eof && (i == len - 1);
            @(negedge clk);
            observe(i + 1, len, exp, (i + 1 == 6) && exp, tag);
            if (poke && i + 1 == 6) begin
                promisc = ~promisc;
                own_mac = rand_addr(1'b0);
                hash_map = ~hash_map;
            end
        end
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        if (with_eof && $urandom_range(0, 2) == 0) begin
            rx_valid = 1'b1; rx_data = 8'($urandom);
            @(negedge clk);
            observe(len, len, exp, 1'b0, "R10");
            rx_valid = 1'b0;
        end
        @(negedge clk);
        observe(len, len, exp, 1'b0, tag);
        if (poke) begin
            own_mac = om; promisc = pm; hash_map = ~hash_map;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [47:0] ma, mb, mc;
        void'($urandom(32'd5150));
        rst_n = 1'b0; rx_valid = 1'b0; rx_data = '0; rx_sof = 1'b0; rx_eof = 1'b0;
        own_mac = rand_addr(1'b0); hash_map = '0; promisc = 1'b0;
        repeat (3) @(negedge clk);
        chk({verdict_valid, verdict_accept, irq_pulse} == 3'b000, "R1", "outputs in reset",
            {verdict_valid, verdict_accept, irq_pulse}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({verdict_valid, verdict_accept, irq_pulse} == 3'b000, "R1", "outputs after reset",
            {verdict_valid, verdict_accept, irq_pulse}, 0);

        send(own_mac, 10, 1, 0, 0, "R2");
        send({own_mac[47:8], ~own_mac[7:0]}, 10, 1, 0, 0, "R5");
        send({~own_mac[47:41], own_mac[40:0]}, 8, 1, 0, 0, "R2");
        send(48'hFFFF_FFFF_FFFF, 7, 1, 0, 0, "R3");
        send(rand_addr(1'b0), 9, 1, 0, 0, "R5");
        promisc = 1'b1;
        send(rand_addr(1'b0), 6, 1, 0, 0, "R6");
        send(rand_addr(1'b0), 4, 1, 0, 0, "R9");
        promisc = 1'b0;
        send(own_mac, 5, 1, 0, 0, "R9");
        send(own_mac, 1, 1, 0, 0, "R9");

        // Group hash: one bit set, a colliding unregistered group, a non-colliding one.
        ma = rand_addr(1'b1);
        hash_map = '0;
        hash_map[bench_hash(ma)] = 1'b1;
        send(ma, 8, 1, 0, 0, "R4");
        mb = rand_addr(1'b1);
        for (int t = 0; t < 5000 && (bench_hash(mb) != bench_hash(ma) || mb == ma); t++)
            mb = rand_addr(1'b1);
        send(mb, 8, 1, 0, 0, "R4");
        mc = rand_addr(1'b1);
        while (bench_hash(mc) == bench_hash(ma)) mc = rand_addr(1'b1);
        send(mc, 8, 1, 0, 0, "R4");
        send(48'hFFFF_FFFF_FFFF, 6, 1, 0, 0, "R3");

        // Restart: partial frame without end marker, then a full frame.
        send(rand_addr(1'b0), 3, 0, 0, 0, "R10");
        send(own_mac, 8, 1, 30, 0, "R10");
        send(ma, 12, 1, 0, 1, "R7");

        for (int n = 0; n < 300; n++) begin
            logic [47:0] da;
            int          sel = $urandom_range(0, 5);
            if (n % 40 == 0) hash_map = (n % 80 == 0) ? {$urandom, $urandom}
                                                      : 64'(1) << $urandom_range(0, 63);
            promisc = ($urandom_range(0, 9) == 0);
            case (sel)
                0:       da = own_mac;
                1:       da = 48'hFFFF_FFFF_FFFF;
                2, 3:    da = rand_addr(1'b1);
                default: da = rand_addr(1'b0);
            endcase
            send(da, $urandom_range(1, 14), ($urandom_range(0, 7) != 0),
                 $urandom_range(0, 1) * 25, ($urandom_range(0, 4) == 0),
                 (sel == 0) ? "R2" : (sel == 1) ? "R3" : (sel < 4) ? "R4" : "R5");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule